// File: doc/BRIEF.md
# Reset and Recovery Sequencer

This block produces the internal hold-in-reset signal of a small microcontroller. It runs on the internal oscillator clock and watches four kinds of event: a supply that is not yet good (power-on or brown-out), a new assertion of the external reset pin, and a wake event out of stop mode. Each event starts a hold sequence. The sequence first waits for the internal oscillator to report that it is running. It then counts a fixed number of oscillator cycles. The count is short by default and long when the crystal option bit is set, so that a crystal has time to settle. If the external pin is still held low when the count runs out, the hold is stretched until the pin is released.

A full reset (supply or pin) clears the peripheral control registers, and the sequencer pulls the shared reset pin low while it counts. A stop-mode recovery resets only the CPU and the watchdog and oscillator control registers, and leaves the pin alone. The watchdog and oscillator control reset is asserted for every hold, so the system clock always comes back on the internal oscillator. A cause register records the most recent reset source. Only a supply event rewrites it to the power-on code.

Top module: `rst_seq_top`

## Requirements
- R1: With `xtalEnable` low, `sysRst` stays high for exactly 66 clock edges, counted from the edge that first samples `oscReady` high in the waiting phase, and goes low on the edge after that.
- R2: With `xtalEnable` high at the edge that starts the count, the hold lasts exactly 5000 clock edges, measured the same way as in R1.
- R3: While `oscReady` is low, the count does not start and `sysRst` stays high, however long the wait.
- R4: `supplyGood` low asserts `sysRst`, `periphRegRst`, `ctlRegRst` and `pinPullDown` at once and sets `lastCause` to 1. Timing begins only after `supplyGood` has passed a two-flop synchronizer.
- R5: If the synchronized pin level is low when the count expires, `sysRst` stays high. After `extRstN` rises, `sysRst` falls on the third clock edge: two synchronizer stages, then the release.
- R6: During a stop-mode recovery hold, `selectiveRst` and `ctlRegRst` are high, and `periphRegRst` and `pinPullDown` are low.
- R7: During a hold caused by the supply or by the pin, `periphRegRst` and `ctlRegRst` are high and `selectiveRst` is low.
- R8: `pinPullDown` is high only during a full-reset hold, while waiting for the oscillator and while counting. It is low while the hold is stretched by the pin, and low outside reset.
- R9: A new pin assertion edge or a `stopWake` pulse during a hold restarts the sequence from the oscillator wait. The count then runs its full length again.
- R10: `lastCause` encodes 1 for power-on, 2 for pin and 3 for stop recovery, and keeps its value across later holds until the next event. A `stopWake` during a full-reset hold changes neither the cause nor the full-reset qualifiers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oscillator clock |
| supplyGood | input | 1 | Supply above threshold; low means power-on or brown-out (asynchronous) |
| extRstN | input | 1 | External reset pin level driven from outside, active low |
| stopWake | input | 1 | Single-cycle stop-mode wake event, synchronous to `clk` |
| oscReady | input | 1 | Internal oscillator has started |
| xtalEnable | input | 1 | Option bit selecting the long hold for crystal start-up |
| sysRst | output | 1 | CPU and system hold-in-reset |
| periphRegRst | output | 1 | Reset qualifier for peripheral control registers (full resets only) |
| ctlRegRst | output | 1 | Reset for the watchdog and oscillator control registers (every hold) |
| selectiveRst | output | 1 | Marks the current hold as a stop-mode recovery |
| pinPullDown | output | 1 | Open-drain pull-down enable for the shared reset pin |
| lastCause | output | 2 | Source of the last reset: 1 power-on, 2 pin, 3 stop |

## Verification
A table of hold sequences crosses the two triggers (pin edge, stop wake) with both crystal settings and with different oscillator-ready delays. A hold that is one cycle off, a count started before the oscillator is ready, or qualifiers that are swapped between full and selective resets each show up as a different failing entry. Directed sequences cover the reset state and the power-on timing, a pin held past expiry to test the stretch and its three-edge release, a second wake in the middle of a count to test the restart length, and a wake inside a pin reset. A final supply drop shows that only a power-on event rewrites the cause register.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_OSC = 2'd0,
    ST_COUNT    = 2'd1,
    ST_PIN_HOLD = 2'd2,
    ST_RUN      = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_POR  = 2'd1,
    CAUSE_PIN  = 2'd2,
    CAUSE_STOP = 2'd3
  } cause_t;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic   cntLoad;
    logic   cntDec;
    logic   causeWr;
    cause_t causeVal;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int SHORT_HOLD  = 66,
  parameter int LONG_HOLD   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       extRstN,
  input  logic       xtalEnable,
  input  seqStrobe_t strobe,
  output logic       porOk,
  output logic       pinLow,
  output logic       pinFall,
  output logic       cntZero,
  output logic [1:0] lastCause
);

  localparam int CNT_W = $clog2(LONG_HOLD);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_HOLD - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_HOLD - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             pinLevel;
  logic             pinPrev;
  cause_t           causeQ;

  // supply-good qualifier: asynchronous assert, two-stage synchronous release
  rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uPorSync (
    .clk   (clk),
    .arstN (supplyGood),
    .d     (1'b1),
    .q     (porOk)
  );

  // pin level; resets to "asserted" so a pin low at power-up only stretches
  rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uPinSync (
    .clk   (clk),
    .arstN (supplyGood),
    .d     (extRstN),
    .q     (pinLevel)
  );

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) pinPrev <= 1'b0;
    else pinPrev <= pinLevel;
  end

  assign pinLow  = ~pinLevel;
  assign pinFall = pinPrev & ~pinLevel;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) holdCnt <= '0;
    else if (strobe.cntLoad) holdCnt <= xtalEnable ? LONG_LOAD : SHORT_LOAD;
    else if (strobe.cntDec) holdCnt <= holdCnt - 1'b1;
  end

  assign cntZero = (holdCnt == '0);

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) causeQ <= CAUSE_POR;
    else if (strobe.causeWr) causeQ <= strobe.causeVal;
  end

  assign lastCause = causeQ;

  // R2: load picks the length from the crystal option
  a_r2_load_value: assert property (@(posedge clk) disable iff (!supplyGood)
    strobe.cntLoad |=> holdCnt == ($past(xtalEnable) ? LONG_LOAD : SHORT_LOAD));

  // R1: each counting cycle removes exactly one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!supplyGood)
    (strobe.cntDec && !strobe.cntLoad) |=> holdCnt == $past(holdCnt) - 1'b1);

  // R10: cause never reads as the unused code
  a_r10_cause_valid: assert property (@(posedge clk) disable iff (!supplyGood)
    causeQ != CAUSE_NONE);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       porOk,
  input  logic       pinLow,
  input  logic       pinFall,
  input  logic       stopWake,
  input  logic       oscReady,
  input  logic       cntZero,
  output seqStrobe_t strobe,
  output logic       holdActive,
  output logic       fullKind,
  output logic       pullEnable
);

  seqState_t state, nextState;
  logic      nextFull;

  always_comb begin
    nextState = state;
    nextFull  = fullKind;
    strobe    = '0;
    if (!porOk) begin
      nextState = ST_WAIT_OSC;
      nextFull  = 1'b1;
    end else if (pinFall) begin
      nextState       = ST_WAIT_OSC;
      nextFull        = 1'b1;
      strobe.causeWr  = 1'b1;
      strobe.causeVal = CAUSE_PIN;
    end else if (stopWake) begin
      nextState = ST_WAIT_OSC;
      // a wake during a full reset keeps the full-reset kind and cause
      if (state == ST_RUN || !fullKind) begin
        nextFull        = 1'b0;
        strobe.causeWr  = 1'b1;
        strobe.causeVal = CAUSE_STOP;
      end
    end else begin
      unique case (state)
        ST_WAIT_OSC: if (oscReady) begin
          strobe.cntLoad = 1'b1;
          nextState      = ST_COUNT;
        end
        ST_COUNT: begin
          if (cntZero) nextState = pinLow ? ST_PIN_HOLD : ST_RUN;
          else strobe.cntDec = 1'b1;
        end
        ST_PIN_HOLD: if (!pinLow) nextState = ST_RUN;
        ST_RUN: nextState = ST_RUN;
        default: nextState = ST_WAIT_OSC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      state    <= ST_WAIT_OSC;
      fullKind <= 1'b1;
    end else begin
      state    <= nextState;
      fullKind <= nextFull;
    end
  end

  assign holdActive = (state != ST_RUN);
  assign pullEnable = fullKind && (state == ST_WAIT_OSC || state == ST_COUNT);

  // R3: no progress out of the oscillator wait without oscReady
  a_r3_wait_osc: assert property (@(posedge clk) disable iff (!supplyGood)
    (state == ST_WAIT_OSC && !oscReady) |=> state == ST_WAIT_OSC);

  // R5: the stretch lasts while the synchronized pin is low
  a_r5_pin_stretch: assert property (@(posedge clk) disable iff (!supplyGood)
    (state == ST_PIN_HOLD && pinLow && !stopWake && porOk) |=> state == ST_PIN_HOLD);

  // R9: a pin edge always restarts at the oscillator wait
  a_r9_restart: assert property (@(posedge clk) disable iff (!supplyGood)
    (porOk && pinFall) |=> (state == ST_WAIT_OSC && fullKind));

  // R1: release only out of an expired count or a finished stretch
  a_r1_release_path: assert property (@(posedge clk) disable iff (!supplyGood)
    (state != ST_RUN) ##1 (state == ST_RUN) |-> ($past(cntZero) || $past(state) == ST_PIN_HOLD));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int SHORT_HOLD  = 66,
  parameter int LONG_HOLD   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       extRstN,
  input  logic       stopWake,
  input  logic       oscReady,
  input  logic       xtalEnable,
  output logic       sysRst,
  output logic       periphRegRst,
  output logic       ctlRegRst,
  output logic       selectiveRst,
  output logic       pinPullDown,
  output logic [1:0] lastCause
);

  seqStrobe_t strobe;
  logic porOk, pinLow, pinFall, cntZero;
  logic holdActive, fullKind, pullEnable;

  rst_seq_datapath #(
    .SHORT_HOLD  (SHORT_HOLD),
    .LONG_HOLD   (LONG_HOLD),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk        (clk),
    .supplyGood (supplyGood),
    .extRstN    (extRstN),
    .xtalEnable (xtalEnable),
    .strobe     (strobe),
    .porOk      (porOk),
    .pinLow     (pinLow),
    .pinFall    (pinFall),
    .cntZero    (cntZero),
    .lastCause  (lastCause)
  );

  rst_seq_ctrl uCtrl (
    .clk        (clk),
    .supplyGood (supplyGood),
    .porOk      (porOk),
    .pinLow     (pinLow),
    .pinFall    (pinFall),
    .stopWake   (stopWake),
    .oscReady   (oscReady),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .holdActive (holdActive),
    .fullKind   (fullKind),
    .pullEnable (pullEnable)
  );

  assign sysRst       = holdActive;
  assign ctlRegRst    = holdActive;
  assign periphRegRst = holdActive & fullKind;
  assign selectiveRst = holdActive & ~fullKind;
  assign pinPullDown  = pullEnable;

  // R6/R7: every hold is exactly one of the two kinds
  a_r6_kind_exclusive: assert property (@(posedge clk) disable iff (!supplyGood)
    sysRst |-> (periphRegRst ^ selectiveRst));

  // R8: the pin is pulled only inside a full reset
  a_r8_pull_in_full: assert property (@(posedge clk) disable iff (!supplyGood)
    pinPullDown |-> (periphRegRst && sysRst));

  // R4: an unsynchronized supply keeps the hold on
  a_r4_supply_hold: assert property (@(posedge clk) disable iff (!supplyGood)
    !porOk |=> sysRst);

endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;

  logic clk = 1'b0;
  logic supplyGood = 1'b0;
  logic extRstN = 1'b1;
  logic stopWake = 1'b0;
  logic oscReady = 1'b0;
  logic xtalEnable = 1'b0;
  logic sysRst, periphRegRst, ctlRegRst, selectiveRst, pinPullDown;
  logic [1:0] lastCause;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rst_seq_top dut (
    .clk          (clk),
    .supplyGood   (supplyGood),
    .extRstN      (extRstN),
    .stopWake     (stopWake),
    .oscReady     (oscReady),
    .xtalEnable   (xtalEnable),
    .sysRst       (sysRst),
    .periphRegRst (periphRegRst),
    .ctlRegRst    (ctlRegRst),
    .selectiveRst (selectiveRst),
    .pinPullDown  (pinPullDown),
    .lastCause    (lastCause)
  );

  typedef struct packed {
    logic        isStop;
    logic        xtal;
    logic [7:0]  oscDelay;
    logic [15:0] expHold;
    logic [1:0]  expCause;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'd3, 16'd66,   2'd2},
    '{1'b1, 1'b0, 8'd5, 16'd66,   2'd3},
    '{1'b0, 1'b1, 8'd2, 16'd5000, 2'd2},
    '{1'b1, 1'b1, 8'd0, 16'd5000, 2'd3},
    '{1'b1, 1'b0, 8'd9, 16'd66,   2'd3}
  };

  task automatic expect_eq(input string req, input string what,
                           input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raise oscReady at a falling edge, count sampled hold edges until release
  task automatic count_hold(output int n);
    n = 0;
    @(negedge clk);
    oscReady = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #1;
      if (!sysRst) break;
      n++;
    end
  endtask

  task automatic pin_pulse();
    @(negedge clk); extRstN = 1'b0;
    cycles(4);
    extRstN = 1'b1;
    cycles(4);
  endtask

  task automatic stop_pulse();
    @(negedge clk); stopWake = 1'b1;
    @(negedge clk); stopWake = 1'b0;
    cycles(2);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // ---- reset state (R4, R7, R8)
    cycles(3); #1;
    expect_eq("R4", "sysRst in supply reset", sysRst, 1);
    expect_eq("R7", "periphRegRst in supply reset", periphRegRst, 1);
    expect_eq("R7", "ctlRegRst in supply reset", ctlRegRst, 1);
    expect_eq("R8", "pinPullDown in supply reset", pinPullDown, 1);
    expect_eq("R4", "lastCause after power-on", lastCause, 1);
    @(negedge clk); supplyGood = 1'b1;
    cycles(20); #1;
    expect_eq("R3", "hold kept without oscReady", sysRst, 1);
    count_hold(n);
    expect_eq("R1", "power-on hold length", n, 66);
    expect_eq("R10", "cause after power-on hold", lastCause, 1);

    // ---- vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk); oscReady = 1'b0; xtalEnable = VECS[v].xtal;
      cycles(2); #1;
      expect_eq("R1", "running before trigger", sysRst, 0);
      if (VECS[v].isStop) stop_pulse(); else pin_pulse();
      cycles(VECS[v].oscDelay); #1;
      expect_eq("R3", "held while oscillator starts", sysRst, 1);
      expect_eq(VECS[v].isStop ? "R6" : "R7", "selectiveRst", selectiveRst, VECS[v].isStop);
      expect_eq(VECS[v].isStop ? "R6" : "R7", "periphRegRst", periphRegRst, !VECS[v].isStop);
      expect_eq(VECS[v].isStop ? "R6" : "R7", "ctlRegRst", ctlRegRst, 1);
      expect_eq("R8", "pinPullDown by kind", pinPullDown, !VECS[v].isStop);
      count_hold(n);
      expect_eq(VECS[v].xtal ? "R2" : "R1", "hold length", n, VECS[v].expHold);
      expect_eq("R10", "cause after hold", lastCause, VECS[v].expCause);
    end

    // ---- pin held past expiry (R5, R8)
    @(negedge clk); oscReady = 1'b0; xtalEnable = 1'b0;
    @(negedge clk); extRstN = 1'b0;
    cycles(5);
    count_hold(n);
    expect_eq("R5", "stretched hold edges", n, 6000);
    #1;
    expect_eq("R5", "sysRst while pin low", sysRst, 1);
    expect_eq("R8", "pinPullDown during stretch", pinPullDown, 0);
    expect_eq("R7", "periphRegRst during stretch", periphRegRst, 1);
    @(negedge clk); extRstN = 1'b1;
    @(posedge clk); #1;
    expect_eq("R5", "release edge 1", sysRst, 1);
    @(posedge clk); #1;
    expect_eq("R5", "release edge 2", sysRst, 1);
    @(posedge clk); #1;
    expect_eq("R5", "release edge 3", sysRst, 0);
    expect_eq("R8", "pinPullDown when running", pinPullDown, 0);

    // ---- restart by a second wake mid-count (R9)
    @(negedge clk); oscReady = 1'b0;
    stop_pulse();
    @(negedge clk); oscReady = 1'b1;
    cycles(30);
    stopWake = 1'b1;
    n = 0;
    @(posedge clk); #1;
    if (sysRst) n++;
    @(negedge clk); stopWake = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (!sysRst) break;
      n++;
    end
    expect_eq("R9", "restarted hold edges", n, 67);

    // ---- wake during a pin reset keeps full kind (R10)
    @(negedge clk); oscReady = 1'b0;
    pin_pulse();
    stop_pulse(); #1;
    expect_eq("R10", "periphRegRst after wake in pin reset", periphRegRst, 1);
    expect_eq("R10", "selectiveRst after wake in pin reset", selectiveRst, 0);
    count_hold(n);
    expect_eq("R10", "hold length after wake", n, 66);
    expect_eq("R10", "cause kept as pin", lastCause, 2);

    // ---- stop cause then supply drop (R4, R10)
    @(negedge clk); oscReady = 1'b0;
    stop_pulse();
    count_hold(n);
    expect_eq("R10", "cause after stop", lastCause, 3);
    @(negedge clk); supplyGood = 1'b0; #1;
    expect_eq("R4", "immediate hold on supply drop", sysRst, 1);
    expect_eq("R4", "cause rewritten by power-on", lastCause, 1);
    expect_eq("R8", "pinPullDown on supply drop", pinPullDown, 1);
    cycles(3);
    supplyGood = 1'b1;
    cycles(100); #1;
    expect_eq("R4", "running after supply returns", sysRst, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule